// File: doc/BRIEF.md
# Source-route to address-route packet converter

This block joins a network interface that builds source-routed packets to a mesh router that steers packets by destination coordinates. On the request path a flit offered by the interface is taken when its valid and ready are both high. A head flit, the one with its begin-of-packet bit set, has its 18-bit hop list swapped for an 8-bit Y/X address found in a programmable table. Every other flit goes through untouched. Flits then leave toward the router on a put / room interface: a flit moves when put and room are both high.

A response path does the reverse. An address-routed head arriving from the router has its Y/X address mapped back to an 18-bit hop list through a second table, and the flit is handed to the interface on a valid/ready handshake. Each path holds a two-place skid register, so it can move one flit per cycle with no combinational path from one handshake to the other. A head that matches no table entry takes a programmable default and sets a sticky miss flag for its direction.

Top module: `route_xlate_bridge`

## Requirements
- R1: After a synchronous active-low reset both outputs that offer flits (`mesh_tx_put`, `ni_rsp_vld`) are low, both ready outputs (`ni_req_rdy`, `mesh_rx_room`) are high, both miss flags are low and no table entry is valid.
- R2: A request flit is 34 bits: bit 33 begin-of-packet, bit 32 end-of-packet, bits 31:0 payload. When bit 33 is set and bits 17:0 equal the key of a valid forward entry, the flit is sent with bits 33:18 unchanged, bits 17:8 zero and bits 7:0 set to that entry's {Y[7:4], X[3:0]} address.
- R3: A flit with bit 33 clear passes through either path bit for bit.
- R4: A request head whose bits 17:0 match no valid forward entry (entries never written do not match, even with key zero) gets the default address in bits 7:0 (bits 17:8 zero, 33:18 kept) and sets `fwd_miss`.
- R5: A response head whose bits 7:0 match a valid reverse entry is sent with bits 33:18 unchanged and bits 17:0 set to that entry's route.
- R6: A response head that matches no valid reverse entry gets the default route in bits 17:0 and sets `rev_miss`.
- R7: Each path delivers flits in acceptance order, one register stage late; a flit on offer stays stable until taken.
- R8: Each path can take a flit whenever fewer than two are held; with the far side always ready it takes one flit every cycle.
- R9: When several valid entries share a key, the lowest index wins; a table or default write takes effect for flits accepted on later cycles.
- R10: A miss flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 1 | 0 selects the forward table, 1 the reverse table |
| cfg_dflt | input | 1 | 1 writes both defaults (address from cfg_addr, route from cfg_route) instead of an entry |
| cfg_idx | input | 4 | Entry index |
| cfg_route | input | 18 | Hop list (key of forward, value of reverse entry) |
| cfg_addr | input | 8 | Y/X address (value of forward, key of reverse entry) |
| ni_req_vld | input | 1 | Interface offers a request flit |
| ni_req_flit | input | 34 | Request flit |
| ni_req_rdy | output | 1 | Block takes the request flit |
| mesh_tx_put | output | 1 | Block offers a flit to the router |
| mesh_tx_flit | output | 34 | Converted request flit |
| mesh_tx_room | input | 1 | Router takes the flit |
| mesh_rx_put | input | 1 | Router offers a response flit |
| mesh_rx_flit | input | 34 | Response flit |
| mesh_rx_room | output | 1 | Block takes the response flit |
| ni_rsp_vld | output | 1 | Block offers a response flit |
| ni_rsp_flit | output | 34 | Converted response flit |
| ni_rsp_rdy | input | 1 | Interface takes the response flit |
| fwd_miss | output | 1 | Sticky forward miss flag |
| rev_miss | output | 1 | Sticky reverse miss flag |

## Verification
The bench builds the block with its default parameters: 16 entries per table, 18-bit hop lists and 8-bit addresses. Twelve forward and ten reverse entries are written, one duplicate key in each, so lowest-index priority, unwritten zero keys and default fallback all occur among random heads. Random stall patterns on both far sides fill the skid registers, and a phase with both sides always ready shows one flit per cycle. Table and default writes are mixed into live traffic, so the rule that a write applies only to later flits is tested in the same cycle.

// File: rtl/rxl_pkg.sv
// Shared widths and flit field positions of the route converter.
// Assumes a 34-bit flit: begin bit on top, end bit below, 32-bit payload.
package rxl_pkg;
    localparam int ROUTE_W = 18;
    localparam int ADDR_W  = 8;
    localparam int PAY_W   = 32;
    localparam int FLIT_W  = PAY_W + 2;
    localparam int BOP_BIT = FLIT_W - 1;
    localparam int KEEP_LO = ROUTE_W;          // head bits kept from here up
    localparam int LUT_N   = 16;
endpackage

// File: rtl/route_lut.sv
// Small fully associative lookup table: DEPTH entries of key -> value.
// Written one entry per cycle; lookup is combinational, lowest index wins.
// Assumes writes and lookups may share a cycle; lookup then sees old content.
module route_lut #(
    parameter int KEY_W = 18,
    parameter int VAL_W = 8,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [KEY_W-1:0] q_key,
    output logic             hit,
    output logic [VAL_W-1:0] q_val
);
    logic [KEY_W-1:0] keys [DEPTH];
    logic [VAL_W-1:0] vals [DEPTH];
    logic [DEPTH-1:0] vld;

    // Entry storage: valid bits cleared on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx]  <= 1'b1;
            keys[wr_idx] <= wr_key;
            vals[wr_idx] <= wr_val;
        end
    end

    // Priority match: scan from the top so the lowest matching index is kept.
    always_comb begin
        hit   = 1'b0;
        q_val = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && keys[i] == q_key) begin
                hit   = 1'b1;
                q_val = vals[i];
            end
        end
    end
endmodule

// File: rtl/flit_skid.sv
// Two-place skid register between two valid/ready style handshakes.
// Ready and valid are both registered, so no combinational path crosses it.
module flit_skid #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         in_rdy,
    output logic         out_vld,
    output logic [W-1:0] out_dat,
    input  logic         out_rdy
);
    logic         m_vld, s_vld;
    logic [W-1:0] m_dat, s_dat;
    logic         push, pop;

    assign in_rdy  = !s_vld;
    assign out_vld = m_vld;
    assign out_dat = m_dat;
    assign push    = in_vld && in_rdy;
    assign pop     = m_vld && out_rdy;

    // Main/skid update: refill main from skid first, else from the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_vld <= 1'b0;
            s_vld <= 1'b0;
        end else if (pop || !m_vld) begin
            if (s_vld) begin
                m_dat <= s_dat;
                s_vld <= 1'b0;
            end else begin
                m_vld <= push;
                m_dat <= in_dat;
            end
        end else if (push) begin
            s_vld <= 1'b1;
            s_dat <= in_dat;
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && !out_rdy |=> out_vld && $stable(out_dat));
    // R8
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rdy |-> out_vld);
endmodule

// File: rtl/route_xlate_bridge.sv
// Converter between a source-routed interface and an address-routed mesh.
// Request heads: hop list -> Y/X address; response heads: address -> hop list.
// Non-head flits pass unchanged. Both sides share one clock.
module route_xlate_bridge
    import rxl_pkg::*;
#(
    parameter int DEPTH = LUT_N,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic              cfg_dflt,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ROUTE_W-1:0] cfg_route,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              ni_req_vld,
    input  logic [FLIT_W-1:0] ni_req_flit,
    output logic              ni_req_rdy,
    output logic              mesh_tx_put,
    output logic [FLIT_W-1:0] mesh_tx_flit,
    input  logic              mesh_tx_room,
    input  logic              mesh_rx_put,
    input  logic [FLIT_W-1:0] mesh_rx_flit,
    output logic              mesh_rx_room,
    output logic              ni_rsp_vld,
    output logic [FLIT_W-1:0] ni_rsp_flit,
    input  logic              ni_rsp_rdy,
    output logic              fwd_miss,
    output logic              rev_miss
);
    localparam int GAP_W = ROUTE_W - ADDR_W;

    logic               tbl_f_we, tbl_r_we, dflt_we;
    logic               f_hit, r_hit;
    logic [ADDR_W-1:0]  f_val, dflt_addr;
    logic [ROUTE_W-1:0] r_val, dflt_route;
    logic [FLIT_W-1:0]  f_conv, r_conv;
    logic               f_head_in, r_head_in;

    assign tbl_f_we  = cfg_we && !cfg_dflt && !cfg_tbl;
    assign tbl_r_we  = cfg_we && !cfg_dflt &&  cfg_tbl;
    assign dflt_we   = cfg_we &&  cfg_dflt;
    assign f_head_in = ni_req_vld && ni_req_rdy && ni_req_flit[BOP_BIT];
    assign r_head_in = mesh_rx_put && mesh_rx_room && mesh_rx_flit[BOP_BIT];

    route_lut #(.KEY_W(ROUTE_W), .VAL_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_fwd_lut (
        .clk, .rst_n, .wr_en(tbl_f_we), .wr_idx(cfg_idx), .wr_key(cfg_route),
        .wr_val(cfg_addr), .q_key(ni_req_flit[ROUTE_W-1:0]), .hit(f_hit), .q_val(f_val));

    route_lut #(.KEY_W(ADDR_W), .VAL_W(ROUTE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_rev_lut (
        .clk, .rst_n, .wr_en(tbl_r_we), .wr_idx(cfg_idx), .wr_key(cfg_addr),
        .wr_val(cfg_route), .q_key(mesh_rx_flit[ADDR_W-1:0]), .hit(r_hit), .q_val(r_val));

    // Head rewrite for both directions; body flits bypass the rewrite.
    always_comb begin
        f_conv = ni_req_flit;
        if (ni_req_flit[BOP_BIT])
            f_conv = {ni_req_flit[FLIT_W-1:KEEP_LO], {GAP_W{1'b0}}, f_hit ? f_val : dflt_addr};
        r_conv = mesh_rx_flit;
        if (mesh_rx_flit[BOP_BIT])
            r_conv = {mesh_rx_flit[FLIT_W-1:KEEP_LO], r_hit ? r_val : dflt_route};
    end

    // Default address/route registers and sticky miss flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_addr  <= '0;
            dflt_route <= '0;
            fwd_miss   <= 1'b0;
            rev_miss   <= 1'b0;
        end else begin
            if (dflt_we) begin
                dflt_addr  <= cfg_addr;
                dflt_route <= cfg_route;
            end
            if (f_head_in && !f_hit) fwd_miss <= 1'b1;
            if (r_head_in && !r_hit) rev_miss <= 1'b1;
        end
    end

    flit_skid #(.W(FLIT_W)) u_req_skid (
        .clk, .rst_n, .in_vld(ni_req_vld), .in_dat(f_conv), .in_rdy(ni_req_rdy),
        .out_vld(mesh_tx_put), .out_dat(mesh_tx_flit), .out_rdy(mesh_tx_room));

    flit_skid #(.W(FLIT_W)) u_rsp_skid (
        .clk, .rst_n, .in_vld(mesh_rx_put), .in_dat(r_conv), .in_rdy(mesh_rx_room),
        .out_vld(ni_rsp_vld), .out_dat(ni_rsp_flit), .out_rdy(ni_rsp_rdy));

    // R10
    fwd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_miss |=> fwd_miss);
    // R10
    rev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_miss |=> rev_miss);
    // R4
    fwd_miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_miss) |-> $past(ni_req_vld && ni_req_rdy && ni_req_flit[BOP_BIT]));
    // R6
    rev_miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rev_miss) |-> $past(mesh_rx_put && mesh_rx_room && mesh_rx_flit[BOP_BIT]));
endmodule

// File: tb/sim_route_xlate_bridge.sv
// Bench: behavioural queue model of both paths, compared every cycle.
module sim_route_xlate_bridge;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_tbl = 0, cfg_dflt = 0;
    logic [3:0] cfg_idx = 0;
    logic [17:0] cfg_route = 0;
    logic [7:0] cfg_addr = 0;
    logic ni_req_vld = 0, mesh_tx_room = 0, mesh_rx_put = 0, ni_rsp_rdy = 0;
    logic [33:0] ni_req_flit = 0, mesh_rx_flit = 0;
    logic ni_req_rdy, mesh_tx_put, mesh_rx_room, ni_rsp_vld, fwd_miss, rev_miss;
    logic [33:0] mesh_tx_flit, ni_rsp_flit;

    route_xlate_bridge u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, mode = 0;
    logic [17:0] fk [16]; logic [7:0] fv [16]; bit fok [16];
    logic [7:0]  rk [16]; logic [17:0] rv [16]; bit rok [16];
    logic [7:0] m_daddr = 0; logic [17:0] m_droute = 0;
    bit m_fmiss = 0, m_rmiss = 0;
    logic [33:0] fq[$], rq[$];
    string fqt[$], rqt[$];

    task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_all(input bit first);
        string tv;
        tv = first ? "R1" : "R7";
        chk(mesh_tx_put == (fq.size() > 0), tv, 34'(mesh_tx_put), 34'(fq.size() > 0));
        if (fq.size() > 0 && mesh_tx_put) chk(mesh_tx_flit == fq[0], fqt[0], mesh_tx_flit, fq[0]);
        chk(ni_req_rdy == (fq.size() < 2), first ? "R1" : "R8", 34'(ni_req_rdy), 34'(fq.size() < 2));
        chk(ni_rsp_vld == (rq.size() > 0), tv, 34'(ni_rsp_vld), 34'(rq.size() > 0));
        if (rq.size() > 0 && ni_rsp_vld) chk(ni_rsp_flit == rq[0], rqt[0], ni_rsp_flit, rq[0]);
        chk(mesh_rx_room == (rq.size() < 2), first ? "R1" : "R8", 34'(mesh_rx_room), 34'(rq.size() < 2));
        chk(fwd_miss == m_fmiss, first ? "R1" : "R10", 34'(fwd_miss), 34'(m_fmiss));
        chk(rev_miss == m_rmiss, first ? "R1" : "R10", 34'(rev_miss), 34'(m_rmiss));
    endtask

    function automatic logic [33:0] pick_flit(input bit fwd);
        logic [33:0] f;
        int c;
        f = {$urandom, $urandom} & 34'h3_FFFF_FFFF;
        f[33] = ($urandom_range(0, 2) == 0);
        if (f[33]) begin
            c = $urandom_range(0, 15);
            if (fwd) f[17:0] = (c < 13) ? fk[c % 12] : (c == 13 ? 18'h0 : 18'($urandom));
            else     f[7:0]  = (c < 12) ? rk[c % 10] : (c == 12 ? 8'h0 : 8'($urandom));
        end
        return f;
    endfunction

    // One cycle: drive, model the coming edge, then check after it.
    task automatic step();
        logic [33:0] e;
        string t;
        bit hit;
        int hi;
        if (mode == 0) begin
            ni_req_vld = 0; mesh_rx_put = 0;
            mesh_tx_room = $urandom_range(0, 1); ni_rsp_rdy = $urandom_range(0, 1);
        end else begin
            ni_req_vld   = (mode == 2) || ($urandom_range(0, 9) < 7);
            mesh_rx_put  = (mode == 2) || ($urandom_range(0, 9) < 7);
            mesh_tx_room = (mode == 2) || ($urandom_range(0, 9) < 6);
            ni_rsp_rdy   = (mode == 2) || ($urandom_range(0, 9) < 6);
            ni_req_flit  = pick_flit(1);
            mesh_rx_flit = pick_flit(0);
        end
        // forward path model
        if (ni_req_vld && fq.size() < 2) begin
            e = ni_req_flit; t = "R3";
            if (e[33]) begin
                hit = 0; hi = 0;
                for (int i = 15; i >= 0; i--) if (fok[i] && fk[i] == e[17:0]) begin hit = 1; hi = i; end
                e[17:0] = {10'b0, hit ? fv[hi] : m_daddr};
                t = hit ? ((hi == 3) ? "R9" : "R2") : "R4";
                if (!hit) m_fmiss = 1;
            end
            if (fq.size() > 0 && mesh_tx_room) begin void'(fq.pop_front()); void'(fqt.pop_front()); end
            fq.push_back(e); fqt.push_back(t);
        end else if (fq.size() > 0 && mesh_tx_room) begin
            void'(fq.pop_front()); void'(fqt.pop_front());
        end
        // reverse path model
        if (mesh_rx_put && rq.size() < 2) begin
            e = mesh_rx_flit; t = "R3";
            if (e[33]) begin
                hit = 0; hi = 0;
                for (int i = 15; i >= 0; i--) if (rok[i] && rk[i] == e[7:0]) begin hit = 1; hi = i; end
                e[17:0] = hit ? rv[hi] : m_droute;
                t = hit ? ((hi == 2) ? "R9" : "R5") : "R6";
                if (!hit) m_rmiss = 1;
            end
            if (rq.size() > 0 && ni_rsp_rdy) begin void'(rq.pop_front()); void'(rqt.pop_front()); end
            rq.push_back(e); rqt.push_back(t);
        end else if (rq.size() > 0 && ni_rsp_rdy) begin
            void'(rq.pop_front()); void'(rqt.pop_front());
        end
        // configuration lands after the lookups of this edge
        if (cfg_we) begin
            if (cfg_dflt) begin m_daddr = cfg_addr; m_droute = cfg_route; end
            else if (!cfg_tbl) begin fok[cfg_idx] = 1; fk[cfg_idx] = cfg_route; fv[cfg_idx] = cfg_addr; end
            else begin rok[cfg_idx] = 1; rk[cfg_idx] = cfg_addr; rv[cfg_idx] = cfg_route; end
        end
        @(negedge clk);
        cyc++;
        cfg_we = 0;
        check_all(0);
    endtask

    task automatic wr(input bit tbl, input bit dflt, input int idx, input logic [17:0] r, input logic [7:0] a);
        cfg_we = 1; cfg_tbl = tbl; cfg_dflt = dflt; cfg_idx = 4'(idx); cfg_route = r; cfg_addr = a;
        step();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            fok[i] = 0; rok[i] = 0;
            fk[i] = 18'(32'h2_5A3C + i * 32'h1_3579); fv[i] = 8'(i * 37 + 5);
            rk[i] = 8'(i * 23 + 9); rv[i] = 18'(32'h1_0F0F ^ (i * 32'h0_4321));
        end
        fk[11] = fk[3];   // duplicate key: entry 3 must win (R9)
        rk[9]  = rk[2];   // duplicate key: entry 2 must win (R9)
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all(1);     // R1 reset state
        wr(0, 1, 0, 18'h2_ABCD, 8'h7E);
        for (int i = 0; i < 12; i++) wr(0, 0, i, fk[i], fv[i]);
        for (int i = 0; i < 10; i++) wr(1, 0, i, rv[i], rk[i]);
        mode = 1;
        repeat (1500) step();
        cfg_we = 1; cfg_tbl = 0; cfg_dflt = 1; cfg_route = 18'h3_1111; cfg_addr = 8'hA5;
        step();            // R9: default change applies to later flits only
        cfg_we = 1; cfg_tbl = 0; cfg_dflt = 0; cfg_idx = 4'd5; cfg_route = fk[5]; cfg_addr = 8'h99;
        fv[5] = fv[5];     // model takes the new value at the edge
        step();
        repeat (1500) step();
        mode = 2;          // R8: both far sides always ready
        repeat (400) step();
        mode = 0;
        repeat (10) step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule